// File: doc/BRIEF.md
# Half-Word Duplicated ALU Checker

This block runs one simple integer operation (add, subtract, AND, OR, XOR) on two narrow operands and checks its own result without a second functional unit. Each operand must fit in the lower half of the data word. The block copies each operand into both halves of the word and runs a single pass through a datapath that is split at the midpoint. That pass produces two independent copies of the result, one in each half. The two halves are compared, and any difference raises a mismatch flag.

The issue logic upstream is expected to send only narrow operands to this path. A request whose operand has any bit set in the upper half is refused, and so is a request with an unsupported operation code. In both cases no result is produced. An accepted request returns its lower-half result, zero-extended to the full width, together with the mismatch flag, one clock after the request. A fault-mask input is XORed onto the raw datapath word before the compare. It stands in for upsets inside the unit.

Top module: `dup_alu_check`

## Requirements
- R1: While reset is held and after it is released, `out_valid` and `mismatch` are 0 and `result` is 0 until the first accepted request.
- R2: An accepted request (`in_valid` high, operands narrow, code supported) gives `out_valid` high in the cycle after the clock edge that samples it. Back-to-back requests give back-to-back results.
- R3: Code 0 (add) returns (a + b) mod 2^(W/2). A carry out of the lower half is dropped and never reaches the upper half.
- R4: Code 1 (subtract) returns (a - b) mod 2^(W/2). A borrow wraps inside the half.
- R5: Codes 2, 3 and 4 return bitwise AND, OR and XOR of the operands.
- R6: Codes 5, 6 and 7 are refused: no `out_valid` follows, and `result` keeps its previous value.
- R7: A request whose `a` or `b` has any nonzero bit in positions W/2 and above is refused: no `out_valid` follows, and `result` is unchanged.
- R8: When the lower half and the upper half of `fault_mask` differ, `mismatch` is 1 with the result. The returned value is the corrupted lower half.
- R9: With `fault_mask` zero, or with equal lower and upper halves of the mask, `mismatch` is 0. Identical flips in both halves are not detected.
- R10: Bits W-1 down to W/2 of `result` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code: 0 add, 1 sub, 2 and, 3 or, 4 xor |
| a | input | W | First operand |
| b | input | W | Second operand |
| fault_mask | input | W | Bits XORed onto the raw datapath word (upset model) |
| out_valid | output | 1 | Result strobe, one cycle after an accepted request |
| result | output | W | Lower-half result, zero-extended |
| mismatch | output | 1 | Halves of the duplicated result disagree |

## Verification
The bench builds the block with W = 16, so each half is 8 bits wide. With this width, random operands often hit carries and borrows across the midpoint, such as 0xFF + 0x01 and 0x00 - 0x01. Random fault masks also produce equal halves often enough to exercise the undetected-fault case. Random operands with upper bits set, and random codes 5 to 7, exercise the refusal paths alongside the accepted traffic.

// File: rtl/dup_alu_check.sv
module dup_alu_check #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] fault_mask,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         mismatch
);
  localparam int H = W / 2;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  logic a_narrow, b_narrow, op_ok, take;
  assign a_narrow = (a[W-1:H] == '0);
  assign b_narrow = (b[W-1:H] == '0);
  assign op_ok    = (op <= OP_XOR);
  assign take     = in_valid & a_narrow & b_narrow & op_ok;

  logic [W-1:0] pa, pb;
  assign pa = {a[H-1:0], a[H-1:0]};
  assign pb = {b[H-1:0], b[H-1:0]};

  logic          is_sub;
  logic [W-1:0]  arith;
  assign is_sub = (op == OP_SUB);

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [H-1:0] bx;
    assign bx = is_sub ? ~pb[g*H +: H] : pb[g*H +: H];
    assign arith[g*H +: H] = pa[g*H +: H] + bx + {{(H-1){1'b0}}, is_sub};
  end

  logic [W-1:0] word;
  always_comb begin
    case (op)
      OP_ADD, OP_SUB: word = arith;
      OP_AND:         word = pa & pb;
      OP_OR:          word = pa | pb;
      default:        word = pa ^ pb;
    endcase
  end

  logic [W-1:0] raw;
  assign raw = word ^ fault_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mismatch  <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= take;
      mismatch  <= take & (raw[H-1:0] != raw[W-1:H]);
      if (take) result <= {{(W-H){1'b0}}, raw[H-1:0]};
    end
  end

  AST_FLAG_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> out_valid); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    result[W-1:H] == '0); // R10
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && a_narrow && b_narrow && op_ok |=> out_valid); // R2
  AST_WIDE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !a_narrow || !b_narrow |=> !out_valid && $stable(result)); // R7
  AST_BAD_OP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    op > OP_XOR |=> !out_valid); // R6
  AST_CLEAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mask[H-1:0] == fault_mask[W-1:H] |=> !mismatch); // R9
endmodule

// File: tb/dup_alu_check_bench.sv
module dup_alu_check_bench;
  localparam int W = 16;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [W-1:0] a = '0, b = '0, fault_mask = '0;
  logic out_valid, mismatch;
  logic [W-1:0] result;

  int total = 0, bad = 0;
  logic [W-1:0] last_res = '0;

  always #2 clk = ~clk;

  dup_alu_check #(.W(W)) u_dup_alu_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .fault_mask(fault_mask), .out_valid(out_valid), .result(result),
    .mismatch(mismatch)
  );

  function automatic logic [H-1:0] golden(input logic [2:0] o, input logic [H-1:0] x, input logic [H-1:0] y);
    case (o)
      3'd0: golden = x + y;
      3'd1: golden = x - y;
      3'd2: golden = x & y;
      3'd3: golden = x | y;
      default: golden = x ^ y;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                     input logic [W-1:0] m, input string req);
    logic acc;
    logic [H-1:0] g, lo, hi;
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; fault_mask = m;
    @(posedge clk);
    #1;
    acc = (x[W-1:H] == '0) && (y[W-1:H] == '0) && (o <= 3'd4);
    g  = golden(o, x[H-1:0], y[H-1:0]);
    lo = g ^ m[H-1:0];
    hi = g ^ m[W-1:H];
    check({req, " valid"}, {15'd0, out_valid}, {15'd0, acc});
    if (acc) begin
      check({req, " result"}, result, {{(W-H){1'b0}}, lo});
      check({req, " mismatch R8/R9"}, {15'd0, mismatch}, {15'd0, lo != hi});
      last_res = {{(W-H){1'b0}}, lo};
    end else begin
      check({req, " result held"}, result, last_res);
      check({req, " no flag"}, {15'd0, mismatch}, 16'd0);
    end
    check("R10 upper zero", {8'd0, result[W-1:H]}, 16'd0);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {15'd0, out_valid}, 16'd0);
    check("R1 reset flag", {15'd0, mismatch}, 16'd0);
    check("R1 reset result", result, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", {15'd0, out_valid}, 16'd0);

    run(3'd0, 16'h00FF, 16'h0001, 16'h0, "R3 add carry");
    run(3'd0, 16'h0080, 16'h0080, 16'h0, "R3 add wrap");
    run(3'd1, 16'h0000, 16'h0001, 16'h0, "R4 sub borrow");
    run(3'd1, 16'h0050, 16'h0020, 16'h0, "R4 sub");
    run(3'd2, 16'h00F0, 16'h003C, 16'h0, "R5 and");
    run(3'd3, 16'h00F0, 16'h000F, 16'h0, "R5 or");
    run(3'd4, 16'h00AA, 16'h00FF, 16'h0, "R5 xor");
    run(3'd5, 16'h0001, 16'h0001, 16'h0, "R6 code5");
    run(3'd7, 16'h0001, 16'h0001, 16'h0, "R6 code7");
    run(3'd0, 16'h0100, 16'h0001, 16'h0, "R7 wide a");
    run(3'd0, 16'h0001, 16'h8000, 16'h0, "R7 wide b");
    run(3'd0, 16'h0012, 16'h0034, 16'h0004, "R8 low flip");
    run(3'd3, 16'h0012, 16'h0034, 16'h0100, "R8 high flip");
    run(3'd4, 16'h0012, 16'h0034, 16'h2121, "R9 equal flips");
    run(3'd2, 16'h00FF, 16'h00FF, 16'h0, "R2 back to back");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      logic [W-1:0] x, y, m;
      o = 3'($urandom_range(0, 7));
      x = {8'd0, 8'($urandom)};
      y = {8'd0, 8'($urandom)};
      if ($urandom_range(0, 9) == 0) x[W-1:H] = 8'($urandom_range(1, 255));
      if ($urandom_range(0, 9) == 0) y[W-1:H] = 8'($urandom_range(1, 255));
      case ($urandom_range(0, 3))
        0: m = 16'($urandom);
        1: begin m[H-1:0] = 8'($urandom); m[W-1:H] = m[H-1:0]; end
        default: m = '0;
      endcase
      run(o, x, y, m, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    @(negedge clk); in_valid = 1'b0;
    @(posedge clk); #1;
    check("R2 idle", {15'd0, out_valid}, 16'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule